// File: doc/BRIEF.md
# Timer DMA Burst Register Window

This block sits inside a timer peripheral. It lets a DMA controller move a run of consecutive timer registers through one fixed data-window address. A selected timer event raises a DMA request. Each access the DMA controller then makes to the window address is steered to the next register in the run. Once the programmed number of beats has been served, the request drops and the run rewinds to its first register.

Software programs three things. The burst control register holds the first register of the run, as a word index, and the beat count minus one. The enable register chooses which of seven event sources may start a burst. The status register latches every event and is cleared by writing zeros. An event that arrives while a burst is running is held and starts the next burst as soon as the current one ends. Beats that fall past the last implemented register read as zero, and writes to them are dropped. The general registers in the word-index range stand in for the rest of the timer and are plain read/write storage.

Top module: `tim_burst_window`

## Requirements
- R1: After reset `dma_req` is low and every register reads zero.
- R2: The burst control register is at byte offset 0x48. The first-register word index is in bits 4:0 and the beat count minus one is in bits 12:8. All other bits read zero. General registers at other word indices read back what was written.
- R3: The enable register is at byte offset 0x0C and holds only bits 14:8; other bits read zero. Source `ev_in[0]` (update) maps to bit 8, `ev_in[1]`..`ev_in[4]` (capture channels 1-4) map to bits 9-12, `ev_in[5]` (commutation) maps to bit 13, and `ev_in[6]` (trigger) maps to bit 14. A one-cycle pulse on an enabled source makes `dma_req` high from the next clock edge.
- R4: A pulse on a source whose enable bit is clear raises no request.
- R5: While `dma_req` is high, successive reads of the window at byte offset 0x4C return registers base, base+1, … in order.
- R6: While `dma_req` is high, successive writes to the window store into registers base, base+1, … in order.
- R7: After beat count-minus-one plus one window accesses, `dma_req` drops and the run rewinds to base. A window access while no request is pending targets base and does not advance.
- R8: A beat whose index is at or above the register count, or is the window's own index, reads zero and ignores writes. The index is the full sum of base and beat, with no wrap.
- R9: An enabled event during a running burst is held. `dma_req` stays high after the last beat, and a full new burst follows.
- R10: The status register at byte offset 0x10 sets bit n on every pulse of `ev_in[n]`, whether or not that source is enabled. A write keeps only the bits written as one, so writing zero clears all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the same cycle as the access |
| ev_in | input | NSRC | One-cycle event pulses, one per source |
| dma_req | output | 1 | DMA request to the controller |

## Verification
Read data is combinational, so the expected value is due in the access cycle itself. The bench drives just after a rising edge, queues the expected word, and its monitor compares on the falling edge of that same cycle. An event pulse, the advance of a window beat and the drop of the request all take effect at the next rising edge. The bench therefore checks `dma_req` one time unit after the edge that ends the stimulus cycle, never at the edge itself.

// File: rtl/tim_burst_window.sv
module tim_burst_window #(
  parameter int NUM_REGS = 20,
  parameter int ADDR_W   = 10,
  parameter int DW       = 32,
  parameter int NSRC     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   ev_in,
  output logic              dma_req
);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int FLD_W   = 5;
  localparam int LEN_LSB = 8;
  localparam int EN_LSB  = 8;
  localparam int MI_W    = $clog2(NUM_REGS);
  localparam logic [WORD_W-1:0] LIM      = WORD_W'(NUM_REGS);
  localparam logic [WORD_W-1:0] IDX_EN   = WORD_W'(3);
  localparam logic [WORD_W-1:0] IDX_SR   = WORD_W'(4);
  localparam logic [WORD_W-1:0] IDX_CTRL = WORD_W'(18);
  localparam logic [WORD_W-1:0] IDX_WIN  = WORD_W'(19);

  logic [DW-1:0]    mem [NUM_REGS];
  logic [FLD_W-1:0] base, len, beat;
  logic [NSRC-1:0]  en, flags;
  logic             pend;

  logic [WORD_W-1:0] word, run_idx, tgt;
  logic              is_win, win_adv, last, hit, do_wr, in_range, generic;
  logic              win_rd_oob;

  assign word     = bus_addr[ADDR_W-1:2];
  assign is_win   = bus_sel && (word == IDX_WIN);
  assign run_idx  = WORD_W'(base) + WORD_W'(beat);
  assign tgt      = is_win ? run_idx : word;
  assign in_range = (tgt < LIM) && (tgt != IDX_WIN);
  assign generic  = in_range && tgt != IDX_EN && tgt != IDX_SR && tgt != IDX_CTRL;
  assign do_wr    = bus_sel && bus_wr && in_range;
  assign win_adv  = is_win && dma_req;
  assign last     = (beat == len);
  assign hit      = |(ev_in & en);
  assign win_rd_oob = is_win && !bus_wr && !in_range;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && in_range) begin
      if (tgt == IDX_CTRL) begin
        bus_rdata[FLD_W-1:0]          = base;
        bus_rdata[LEN_LSB +: FLD_W]   = len;
      end else if (tgt == IDX_EN) begin
        bus_rdata[EN_LSB +: NSRC]     = en;
      end else if (tgt == IDX_SR) begin
        bus_rdata[NSRC-1:0]           = flags;
      end else begin
        bus_rdata = mem[tgt[MI_W-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (do_wr && generic) begin
      mem[tgt[MI_W-1:0]] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      len   <= '0;
      en    <= '0;
      flags <= '0;
    end else begin
      if (do_wr && tgt == IDX_CTRL) begin
        base <= bus_wdata[FLD_W-1:0];
        len  <= bus_wdata[LEN_LSB +: FLD_W];
      end
      if (do_wr && tgt == IDX_EN) en <= bus_wdata[EN_LSB +: NSRC];
      if (do_wr && tgt == IDX_SR) flags <= (flags & bus_wdata[NSRC-1:0]) | ev_in;
      else                        flags <= flags | ev_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_req <= 1'b0;
      pend    <= 1'b0;
      beat    <= '0;
    end else if (win_adv && last) begin
      beat    <= '0;
      dma_req <= pend | hit;
      pend    <= 1'b0;
    end else begin
      if (win_adv) beat <= beat + 1'b1;
      if (hit) begin
        if (dma_req) pend <= 1'b1;
        else         dma_req <= 1'b1;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^bus_addr[1:0];
endmodule

// File: rtl/tim_burst_window_chk.sv
module tim_burst_window_chk #(
  parameter int FLD_W = 5,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_req,
  input logic             pend,
  input logic             hit,
  input logic             win_adv,
  input logic             win_rd_oob,
  input logic [FLD_W-1:0] beat,
  input logic [FLD_W-1:0] len,
  input logic [DW-1:0]    bus_rdata
);
  p_req_from_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(hit));

  p_idle_rewound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |-> beat == '0);

  p_drop_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_adv && beat == len && !pend && !hit) |=> !dma_req);

  p_pend_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> dma_req);

  p_pend_resumes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_adv && beat == len && pend) |=> dma_req && beat == '0);

  p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd_oob |-> bus_rdata == '0);
endmodule

bind tim_burst_window tim_burst_window_chk #(.FLD_W(FLD_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .pend(pend), .hit(hit),
  .win_adv(win_adv), .win_rd_oob(win_rd_oob), .beat(beat), .len(len),
  .bus_rdata(bus_rdata)
);

// File: tb/test_tim_burst_window.sv
module test_tim_burst_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  ev_in = '0;
  logic        dma_req;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  tim_burst_window i_tim_burst_window (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_in(ev_in), .dma_req(dma_req)
  );

  function automatic logic [31:0] val(input int i);
    return 32'hA000_0000 + 32'(i) * 32'h0000_0111;
  endfunction

  always @(negedge clk) begin
    if (bus_sel && !bus_wr && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s read 0x%03h actual=%08h expected=%08h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic chk_req(input logic e, input string t);
    n_cmp++;
    if (dma_req !== e) begin
      n_bad++;
      $display("FAIL %s dma_req actual=%b expected=%b", t, dma_req, e);
    end
  endtask

  task automatic bw(input int a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input int a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 10'(a);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] m);
    ev_in = m;
    @(posedge clk); #1;
    ev_in = '0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_req(1'b0, "R1");
    br(12'h48, 0, "R1"); br(12'h0C, 0, "R1"); br(12'h10, 0, "R1"); br(12'h14, 0, "R1");

    for (int i = 0; i < 18; i++) if (i != 3 && i != 4) bw(i * 4, val(i));
    br(12'h14, val(5), "R2"); br(12'h44, val(17), "R2");
    bw(12'h48, 32'hFFFF_E2E5);
    br(12'h48, 32'h0000_0205, "R2");

    bw(12'h0C, 32'hFFFF_FFFF);
    br(12'h0C, 32'h0000_7F00, "R3");
    bw(12'h0C, 32'h0000_0200);
    bw(12'h10, 0);

    pulse(7'b0000001);
    chk_req(1'b0, "R4");
    br(12'h10, 32'h1, "R10");

    pulse(7'b0000010);
    chk_req(1'b1, "R3");
    br(12'h4C, val(5), "R5");
    br(12'h4C, val(6), "R5");
    chk_req(1'b1, "R7");
    br(12'h4C, val(7), "R5");
    chk_req(1'b0, "R7");
    br(12'h4C, val(5), "R7");
    br(12'h4C, val(5), "R7");
    chk_req(1'b0, "R7");

    br(12'h10, 32'h3, "R10");
    bw(12'h10, 32'h2);
    br(12'h10, 32'h2, "R10");
    bw(12'h10, 0);
    br(12'h10, 32'h0, "R10");

    bw(12'h48, 32'h0105);
    pulse(7'b0000010);
    chk_req(1'b1, "R6");
    bw(12'h4C, 32'h1111_0001);
    bw(12'h4C, 32'h2222_0002);
    chk_req(1'b0, "R7");
    br(12'h14, 32'h1111_0001, "R6");
    br(12'h18, 32'h2222_0002, "R6");
    br(12'h1C, val(7), "R6");

    bw(12'h48, 32'h0208);
    bw(12'h0C, 32'h0000_4200);
    pulse(7'b1000000);
    chk_req(1'b1, "R3");
    br(12'h4C, val(8), "R9");
    pulse(7'b0000010);
    chk_req(1'b1, "R9");
    br(12'h4C, val(9), "R9");
    br(12'h4C, val(10), "R9");
    chk_req(1'b1, "R9");
    br(12'h4C, val(8), "R9");
    br(12'h4C, val(9), "R9");
    br(12'h4C, val(10), "R9");
    chk_req(1'b0, "R9");

    bw(12'h48, 32'h0311);
    pulse(7'b0000010);
    br(12'h4C, val(17), "R8");
    br(12'h4C, 32'h0000_0311, "R8");
    br(12'h4C, 0, "R8");
    br(12'h4C, 0, "R8");
    chk_req(1'b0, "R8");

    bw(12'h48, 32'h011F);
    bw(12'h0C, 32'h0000_2000);
    pulse(7'b0100000);
    chk_req(1'b1, "R3");
    bw(12'h4C, 32'h0000_DEAD);
    bw(12'h4C, 32'h0000_BEEF);
    chk_req(1'b0, "R8");
    br(12'h00, val(0), "R8");
    br(12'h04, val(1), "R8");
    br(12'h7C, 0, "R8");
    br(12'h48, 32'h0000_011F, "R8");

    pulse(7'b0000010);
    chk_req(1'b0, "R4");

    @(posedge clk); #1;
    summary();
  end
endmodule